// File: doc/BRIEF.md
# Serial Sampling Converter Port with Power-Mode Control

This block is the digital half of an 8-bit serial sampling converter, written as synthesizable logic that runs on a system clock. It watches an active-low chip select and a serial clock, both sampled on the system clock. A parallel sample word stands in for the converter core. A falling chip select starts a frame. The block latches the sample word, moves the sampler from track to hold, and enables the serial data output. Over 16 serial-clock cycles the block shifts out a fixed frame. Each new bit appears on a falling serial-clock edge, so a host can capture it on the following falling edge.

The number of falling serial-clock edges seen before chip select rises decides what the release means. An early release is ignored. A release in the middle of the word powers the part down. A late release cuts the word short but leaves the part powered. After reset, or after a power-down, the next frame wakes the part. The result of that frame is marked as a dummy. A wake frame must run to completion before results are marked good again.

The serial output is modelled as a data bit plus an output-enable bit; the pad cell makes the tri-state. The chip select and serial clock must already be synchronous to `clk`. One edge of each may be seen per system clock. Chip select and serial data carry no valid/ready handshake: the host paces the transfer by driving the serial clock, and the block has no way to stall it.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, `shutdown_o`=1, `sdata_oe`=0, `sdata_o`=0, `hold_o`=0 (track) and `frame_done_o`=0. The first frame is a dummy.
- R2: A chip select fall sets `sdata_oe`=1 and `hold_o`=1 one clock later, and the first bit shown is 0.
- R3: After k falling serial edges of a frame, the output bit is 0 for k=0..2. For k=3..10 it is sample bit 10-k, which is straight binary with the MSB first. For k=11..15 it is 0.
- R4: `hold_o` stays 1 through the 12th rising serial edge. It returns to 0 on the 13th rising edge or on a chip select rise, whichever comes first.
- R5: `sdata_oe` returns to 0 on the 16th falling edge or on chip select rising, whichever comes first. The 16th falling edge gives a one-clock `frame_done_o` pulse. The output stays disabled while chip select idles low after the frame.
- R6: In a powered frame, a chip select rise after fewer than 2 falling edges leaves the power mode unchanged.
- R7: In a powered frame, a chip select rise after 2 to 9 falling edges aborts the word and sets `shutdown_o`=1. The next frame is then a dummy.
- R8: In a powered frame, a chip select rise after 10 to 15 falling edges truncates the word. `shutdown_o` stays 0 and no `frame_done_o` pulse is given.
- R9: A frame that starts in shutdown reports `dummy_o`=1. `shutdown_o` falls on that frame's 10th falling edge. A chip select rise before that edge leaves the part in shutdown.
- R10: `dummy_o` falls to 0 only on a frame that follows a wake frame which reached its 16th falling edge. A wake frame released after 10 to 15 falling edges leaves the next frame marked as a dummy.
- R11: The sample word is latched at the chip select fall. Later changes to `sample_in` do not change the shifted bits.
- R12: A falling serial edge seen in the same clock as a chip select rise is counted before the release is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| sample_in | input | DATA_W | Parallel conversion result from the core |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Serial data output enable (0 = high impedance) |
| hold_o | output | 1 | 1 = hold, 0 = track |
| shutdown_o | output | 1 | 1 = powered down |
| dummy_o | output | 1 | The current or last frame result is not usable |
| frame_done_o | output | 1 | One-clock pulse after the 16th falling edge |

## Verification
The release decision and the falling-edge counter can act in the same system clock: chip select rises in the very cycle that carries a falling serial edge. The bench provokes this by driving `sclk` low and `cs_n` high at the same instant. It does so at the 2nd, the 10th and the 16th falling edge. The bench judges each case by the resulting mode, by the `frame_done_o` pulse, and by the dummy marking of the next frame. A falling edge counted first moves each release into the higher band.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    REL_IGNORE,
    REL_SLEEP,
    REL_TRUNC,
    REL_DONE
  } rel_e;

  // Classify a chip select release by the falling edges counted so far.
  function automatic rel_e release_kind(input int unsigned n,
                                        input int unsigned sleep_min,
                                        input int unsigned keep_min,
                                        input int unsigned frame_len);
    if (n < sleep_min)      return REL_IGNORE;
    else if (n < keep_min)  return REL_SLEEP;
    else if (n < frame_len) return REL_TRUNC;
    else                    return REL_DONE;
  endfunction

endpackage

// File: rtl/sar_edge.sv
module sar_edge #(
  parameter int          WIDTH = 2,
  parameter logic [1:0]  IDLE  = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE[WIDTH-1:0];
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/sar_framer.sv
module sar_framer #(
  parameter int DATA_W     = 8,
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 3,
  parameter int TRACK_RISE = 13,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              hold_o,
  output logic              frame_done_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  fall_cnt_nx,
  output logic              frame_end_now
);
  localparam int TRAIL = FRAME_LEN - LEAD_ZEROS - DATA_W;
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TRK_AT = CNT_W'(TRACK_RISE - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [CNT_W-1:0]     fcnt, rcnt;
  logic                 active, oe, hold, done;
  logic                 fall_ok, rise_ok;

  assign fall_ok = active && sclk_fall && (fcnt != FULL);
  assign rise_ok = active && sclk_rise && (rcnt != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      fcnt   <= '0;
      rcnt   <= '0;
      active <= 1'b0;
      oe     <= 1'b0;
      hold   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cs_fall) begin
        shreg  <= {{LEAD_ZEROS{1'b0}}, sample_in, {TRAIL{1'b0}}};
        fcnt   <= '0;
        rcnt   <= '0;
        active <= 1'b1;
        oe     <= 1'b1;
        hold   <= 1'b1;
      end else if (active) begin
        if (fall_ok) begin
          fcnt  <= fcnt + CNT_W'(1);
          shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
          if (fcnt == LAST_F) begin
            oe   <= 1'b0;
            done <= 1'b1;
          end
        end
        if (rise_ok) begin
          rcnt <= rcnt + CNT_W'(1);
          if (rcnt == TRK_AT) hold <= 1'b0;
        end
        if (cs_rise) begin
          active <= 1'b0;
          oe     <= 1'b0;
          hold   <= 1'b0;
        end
      end
    end
  end

  assign sdata_o       = oe & shreg[FRAME_LEN-1];
  assign sdata_oe      = oe;
  assign hold_o        = hold;
  assign frame_done_o  = done;
  assign active_o      = active;
  assign fall_cnt_nx   = fcnt + CNT_W'(fall_ok);
  assign frame_end_now = fall_ok && (fcnt == LAST_F);
endmodule

// File: rtl/sar_power.sv
module sar_power
  import sar_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int SLEEP_MIN = 2,
  parameter int KEEP_MIN  = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             active,
  input  logic [CNT_W-1:0] fall_cnt_nx,
  input  logic             frame_end_now,
  output logic             shutdown_o,
  output logic             dummy_o
);
  logic asleep, pend, wake, fdummy;
  rel_e kind;

  assign kind = release_kind(int'(fall_cnt_nx), SLEEP_MIN, KEEP_MIN, FRAME_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b1;
      pend   <= 1'b1;
      wake   <= 1'b0;
      fdummy <= 1'b1;
    end else if (cs_fall) begin
      fdummy <= asleep | pend;
      wake   <= asleep;
    end else if (active) begin
      if (wake && asleep && (kind != REL_IGNORE) && (kind != REL_SLEEP))
        asleep <= 1'b0;
      if (frame_end_now)
        pend <= 1'b0;
      if (cs_rise && !wake && (kind == REL_SLEEP)) begin
        asleep <= 1'b1;
        pend   <= 1'b1;
      end
    end
  end

  assign shutdown_o = asleep;
  assign dummy_o    = fdummy;
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W     = 8,
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 3,
  parameter int TRACK_RISE = 13,
  parameter int SLEEP_MIN  = 2,
  parameter int KEEP_MIN   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              hold_o,
  output logic              shutdown_o,
  output logic              dummy_o,
  output logic              frame_done_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic [1:0]       rise, fall;
  logic             active, frame_end_now;
  logic [CNT_W-1:0] fall_cnt_nx;

  // bit 0: chip select level (idles high), bit 1: serial clock (idles low)
  sar_edge #(.WIDTH(2), .IDLE(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i({sclk, cs_n}),
    .rise_o(rise), .fall_o(fall)
  );

  sar_framer #(
    .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .LEAD_ZEROS(LEAD_ZEROS),
    .TRACK_RISE(TRACK_RISE), .CNT_W(CNT_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(fall[0]), .cs_rise(rise[0]),
    .sclk_rise(rise[1]), .sclk_fall(fall[1]),
    .sample_in(sample_in),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .hold_o(hold_o),
    .frame_done_o(frame_done_o), .active_o(active),
    .fall_cnt_nx(fall_cnt_nx), .frame_end_now(frame_end_now)
  );

  sar_power #(
    .FRAME_LEN(FRAME_LEN), .SLEEP_MIN(SLEEP_MIN), .KEEP_MIN(KEEP_MIN),
    .CNT_W(CNT_W)
  ) u_power (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(fall[0]), .cs_rise(rise[0]), .active(active),
    .fall_cnt_nx(fall_cnt_nx), .frame_end_now(frame_end_now),
    .shutdown_o(shutdown_o), .dummy_o(dummy_o)
  );
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sdata_o,
  input logic sdata_oe,
  input logic hold_o,
  input logic shutdown_o,
  input logic dummy_o,
  input logic frame_done_o
);
  assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> hold_o && !sdata_o);

  assert_data_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_o |-> sdata_oe && hold_o);

  assert_done_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !sdata_oe);

  assert_sleep_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_o) |-> !sdata_oe && !hold_o);

  assert_wake_dummy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown_o) |-> dummy_o);

  assert_done_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !shutdown_o);
endmodule

bind sar_serial_port sar_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
  .hold_o(hold_o), .shutdown_o(shutdown_o), .dummy_o(dummy_o),
  .frame_done_o(frame_done_o)
);

// File: tb/sar_serial_port_tb_top.sv
module sar_serial_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [7:0] sample_in = 8'h00;
  logic       sdata_o, sdata_oe, hold_o, shutdown_o, dummy_o, frame_done_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic last_done;

  always #10 clk = ~clk;

  sar_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .hold_o(hold_o),
    .shutdown_o(shutdown_o), .dummy_o(dummy_o), .frame_done_o(frame_done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  // one serial clock cycle: rise then fall; last_done samples the pulse slot
  task automatic pulse();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    @(negedge clk) sclk = 1'b0;
    @(negedge clk) last_done = frame_done_o;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  // falling edge and chip select release in the same system clock
  task automatic fall_with_release();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    @(negedge clk) begin sclk = 1'b0; cs_n = 1'b1; end
    @(negedge clk) last_done = frame_done_o;
  endtask

  // full frame; checks bit stream, hold timing, enable, done pulse
  task automatic full_frame(input logic [7:0] w, input logic exp_dummy, input logic change_input);
    logic [15:0] got;
    logic [15:0] exp;
    exp = {3'b000, w, 5'b00000};
    sample_in = w;
    cs_low();
    chk("R2 oe after cs fall", int'(sdata_oe), 1);
    chk("R2 hold after cs fall", int'(hold_o), 1);
    chk("R10 dummy mark", int'(dummy_o), int'(exp_dummy));
    if (change_input) sample_in = ~w;
    got[15] = sdata_o;
    for (int k = 1; k < 16; k++) begin
      pulse();
      got[15-k] = sdata_o;
      if (k == 12) chk("R4 hold after 12 rises", int'(hold_o), 1);
      if (k == 13) chk("R4 track after 13 rises", int'(hold_o), 0);
      if (k == 15) chk("R5 oe before 16th fall", int'(sdata_oe), 1);
    end
    if (change_input) chk("R11 latched word", int'(got), int'(exp));
    else              chk("R3 bit stream", int'(got), int'(exp));
    pulse();
    chk("R5 done pulse on 16th fall", int'(last_done), 1);
    chk("R5 oe off after 16th fall", int'(sdata_oe), 0);
    @(negedge clk);
    chk("R5 done pulse one clock", int'(frame_done_o), 0);
    pulses(2);
    chk("R5 oe stays off with cs idle low", int'(sdata_oe), 0);
    cs_high();
  endtask

  task automatic t_reset();
    chk("R1 shutdown at reset", int'(shutdown_o), 1);
    chk("R1 oe at reset", int'(sdata_oe), 0);
    chk("R1 sdata at reset", int'(sdata_o), 0);
    chk("R1 track at reset", int'(hold_o), 0);
    chk("R1 done at reset", int'(frame_done_o), 0);
  endtask

  task automatic t_wake_full();
    sample_in = 8'hA5;
    cs_low();
    chk("R9 wake frame dummy", int'(dummy_o), 1);
    pulses(9);
    chk("R9 asleep before 10th fall", int'(shutdown_o), 1);
    pulse();
    chk("R9 awake at 10th fall", int'(shutdown_o), 0);
    pulses(6);
    chk("R5 wake frame done", int'(last_done), 1);
    cs_high();
  endtask

  task automatic t_normal();
    full_frame(8'h3C, 1'b0, 1'b0);
    full_frame(8'hFF, 1'b0, 1'b0);
    full_frame(8'h00, 1'b0, 1'b0);
    full_frame(8'h81, 1'b0, 1'b1);
  endtask

  task automatic t_ignore();
    cs_low();
    pulse();
    cs_high();
    chk("R6 early release keeps mode", int'(shutdown_o), 0);
    chk("R5 oe off on early release", int'(sdata_oe), 0);
    chk("R4 track on release", int'(hold_o), 0);
    full_frame(8'h5A, 1'b0, 1'b0);
  endtask

  task automatic t_truncate();
    cs_low();
    pulses(12);
    cs_high();
    chk("R8 truncated stays powered", int'(shutdown_o), 0);
    chk("R8 oe off on truncation", int'(sdata_oe), 0);
    chk("R8 no done on truncation", int'(frame_done_o), 0);
    full_frame(8'h69, 1'b0, 1'b0);
  endtask

  task automatic t_sleep_and_partial_wake();
    cs_low();
    pulses(5);
    cs_high();
    chk("R7 release mid-word sleeps", int'(shutdown_o), 1);
    chk("R7 track after sleep", int'(hold_o), 0);
    cs_low();
    chk("R7 next frame dummy", int'(dummy_o), 1);
    pulses(4);
    cs_high();
    chk("R9 early wake release stays asleep", int'(shutdown_o), 1);
    cs_low();
    pulses(11);
    cs_high();
    chk("R9 partial wake powered", int'(shutdown_o), 0);
    full_frame(8'h12, 1'b1, 1'b0);
    full_frame(8'h34, 1'b0, 1'b0);
  endtask

  task automatic t_coincident();
    cs_low();
    pulses(9);
    fall_with_release();
    chk("R12 release with 10th fall truncates", int'(shutdown_o), 0);
    cs_low();
    pulses(15);
    fall_with_release();
    chk("R12 release with 16th fall completes", int'(last_done), 1);
    chk("R12 powered after 16th fall release", int'(shutdown_o), 0);
    cs_low();
    chk("R12 frame after coincident completion valid", int'(dummy_o), 0);
    pulse();
    fall_with_release();
    chk("R12 release with 2nd fall sleeps", int'(shutdown_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake_full();
    t_normal();
    t_ignore();
    t_truncate();
    t_sleep_and_partial_wake();
    t_coincident();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule